// File: doc/BRIEF.md
# Platform System-Control Register Port

This block is a byte-wide register file on a simple synchronous I/O bus. It decodes a fixed set of port addresses and keeps the platform control state: a soft-reset request, a little-endian mode flag, a disk-activity light, a nibble of system/cache control bits and the I/O map mode. Other ports return fixed board identity and equipment bytes. Two ports do not store anything when written. Instead, each such write emits a one-cycle pulse that toggles one of two NVRAM lock channels.

A bus master presents an address with a write strobe and write data, or with a read strobe. Control outputs change on the clock edge that samples a write. Read data is registered and appears one cycle after the read strobe. It then holds until the next read. Any access to a port the block does not handle raises a one-cycle error flag. Reads of such ports return 0xFF, and writes to them change nothing.

Top module: `sysctl_regport`

## Requirements
- R1: After reset, rdata is 0x00 and err, reset_req, endian_le, disk_light, contig_map, lock_tog1 and lock_tog2 are all 0. The system control nibble reads as 0.
- R2: A write to port 0x092 sets reset_req to data bit 0 and endian_le to data bit 1. Both are visible in the cycle after the write.
- R3: A read of port 0x092 returns endian_le in bit 1, with every other bit 0.
- R4: Reads of the identity ports return fixed values: 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x818 gives 0x00 and 0x823 gives 0x03. Writes to 0x800, 0x802 and 0x803 are accepted without error and change no output.
- R5: A write to port 0x808 sets disk_light to data bit 0.
- R6: A write to port 0x810 makes lock_tog1 high for exactly one cycle. A write to port 0x812 does the same for lock_tog2. The data value is ignored.
- R7: A write to port 0x81C stores data bits 3:0. A read of 0x81C returns the stored nibble in bits 3:0, with bits 7:4 zero.
- R8: A write to port 0x850 stores data bit 0 and drives it onto contig_map. A read of 0x850 returns that bit in bit 0, with the other bits zero.
- R9: A read of port 0x810 returns 0x39. Reads of undecoded ports return 0xFF. The undecoded ports include 0x808, 0x812 and 0x814, and every address outside the lists in R2 to R8. Writes to undecoded ports, including 0x80C, 0x814, 0x818 and 0x823, change no output.
- R10: Read data appears one cycle after rd_en. It holds its value through cycles without rd_en, including write cycles.
- R11: err is high for exactly the cycle after an undecoded read or write, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Port address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| err | output | 1 | One-cycle undecoded-access flag |
| reset_req | output | 1 | Soft-reset request |
| endian_le | output | 1 | Little-endian mode flag |
| disk_light | output | 1 | Disk-activity indicator |
| contig_map | output | 1 | Contiguous I/O map mode |
| lock_tog1 | output | 1 | NVRAM lock toggle pulse, channel 1 |
| lock_tog2 | output | 1 | NVRAM lock toggle pulse, channel 2 |

## Verification
Every result of this block is due exactly one cycle after the access that causes it:
- control outputs and lock pulses one edge after the write strobe,
- rdata one edge after the read strobe,
- err one edge after an undecoded access.

The driver applies each access on a falling edge and queues the expected values tagged with the cycle number one greater than the current one. The monitor compares them shortly after the next rising edge. Because every operation also queues the pulse lines and rdata for the following cycle, the bench checks that pulses last exactly one cycle and that read data holds.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W = 8;
    localparam int SC_W   = 4;
    localparam int NPORT  = 11;

    // port slot indices
    localparam int PI_SPECIAL = 0;
    localparam int PI_CPUCFG  = 1;
    localparam int PI_FEAT    = 2;
    localparam int PI_STAT    = 3;
    localparam int PI_LIGHT   = 4;
    localparam int PI_EQUIP   = 5;
    localparam int PI_PW1     = 6;
    localparam int PI_PW2     = 7;
    localparam int PI_KEYLK   = 8;
    localparam int PI_SYSCTL  = 9;
    localparam int PI_MAP     = 10;
    // 0x823 is handled as a read-only slot past the table end
    localparam logic [15:0] L2STAT_ADDR = 16'h0823;

    localparam logic [DATA_W-1:0] K_CPUCFG = 8'hEF;
    localparam logic [DATA_W-1:0] K_FEAT   = 8'hAD;
    localparam logic [DATA_W-1:0] K_STAT   = 8'hE0;
    localparam logic [DATA_W-1:0] K_EQUIP  = 8'h3C;
    localparam logic [DATA_W-1:0] K_EXTF   = 8'h39;
    localparam logic [DATA_W-1:0] K_KEYLK  = 8'h00;
    localparam logic [DATA_W-1:0] K_L2STAT = 8'h03;
    localparam logic [DATA_W-1:0] K_NONE   = 8'hFF;

    function automatic logic [15:0] port_addr(input int idx);
        case (idx)
            PI_SPECIAL: port_addr = 16'h0092;
            PI_CPUCFG:  port_addr = 16'h0800;
            PI_FEAT:    port_addr = 16'h0802;
            PI_STAT:    port_addr = 16'h0803;
            PI_LIGHT:   port_addr = 16'h0808;
            PI_EQUIP:   port_addr = 16'h080C;
            PI_PW1:     port_addr = 16'h0810;
            PI_PW2:     port_addr = 16'h0812;
            PI_KEYLK:   port_addr = 16'h0818;
            PI_SYSCTL:  port_addr = 16'h081C;
            PI_MAP:     port_addr = 16'h0850;
            default:    port_addr = 16'hFFFF;
        endcase
    endfunction

    function automatic logic [NPORT-1:0] wr_mask_f();
        logic [NPORT-1:0] m;
        m = '0;
        m[PI_SPECIAL] = 1'b1;
        m[PI_CPUCFG]  = 1'b1;
        m[PI_FEAT]    = 1'b1;
        m[PI_STAT]    = 1'b1;
        m[PI_LIGHT]   = 1'b1;
        m[PI_PW1]     = 1'b1;
        m[PI_PW2]     = 1'b1;
        m[PI_SYSCTL]  = 1'b1;
        m[PI_MAP]     = 1'b1;
        return m;
    endfunction

    function automatic logic [NPORT-1:0] rd_mask_f();
        logic [NPORT-1:0] m;
        m = '0;
        m[PI_SPECIAL] = 1'b1;
        m[PI_CPUCFG]  = 1'b1;
        m[PI_FEAT]    = 1'b1;
        m[PI_STAT]    = 1'b1;
        m[PI_EQUIP]   = 1'b1;
        m[PI_PW1]     = 1'b1;
        m[PI_KEYLK]   = 1'b1;
        m[PI_SYSCTL]  = 1'b1;
        m[PI_MAP]     = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        logic            rst_req;
        logic            endian;
        logic            light;
        logic [SC_W-1:0] sc;
        logic            cmap;
        logic            pulse1;
        logic            pulse2;
    } ctl_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
    } bus_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NPORT-1:0]  hit,
    output logic              hit_l2,
    output logic              rd_ok,
    output logic              wr_ok
);
    localparam logic [NPORT-1:0] WR_MASK = wr_mask_f();
    localparam logic [NPORT-1:0] RD_MASK = rd_mask_f();

    for (genvar i = 0; i < NPORT; i++) begin : g_cmp
        assign hit[i] = (addr == ADDR_W'(port_addr(i)));
    end

    assign hit_l2 = (addr == ADDR_W'(L2STAT_ADDR));

    always_comb begin
        rd_ok = (|(hit & RD_MASK)) | hit_l2;
        wr_ok = |(hit & WR_MASK);
    end

endmodule

// File: rtl/sysctl_ctl.sv
module sysctl_ctl
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NPORT-1:0]  hit,
    output ctl_t              ctl_q
);
    ctl_t ctl_d;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:SC_W];

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.pulse1 = 1'b0;
        ctl_d.pulse2 = 1'b0;
        if (wr_en) begin
            if (hit[PI_SPECIAL]) begin
                ctl_d.rst_req = wdata[0];
                ctl_d.endian  = wdata[1];
            end
            if (hit[PI_LIGHT])  ctl_d.light  = wdata[0];
            if (hit[PI_PW1])    ctl_d.pulse1 = 1'b1;
            if (hit[PI_PW2])    ctl_d.pulse2 = 1'b1;
            if (hit[PI_SYSCTL]) ctl_d.sc     = wdata[SC_W-1:0];
            if (hit[PI_MAP])    ctl_d.cmap   = wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    a_r2_special_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && hit[PI_SPECIAL] |=>
            (ctl_q.rst_req == $past(wdata[0])) && (ctl_q.endian == $past(wdata[1])));

    a_r6_pulse1_source: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.pulse1 |-> $past(wr_en && hit[PI_PW1]));

    a_r6_pulse2_source: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.pulse2 |-> $past(wr_en && hit[PI_PW2]));

    a_r7_sc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit[PI_SYSCTL]) |=> $stable(ctl_q.sc));

    a_r8_map_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit[PI_MAP]) |=> $stable(ctl_q.cmap));

    a_r5_light_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit[PI_LIGHT]) |=> $stable(ctl_q.light));

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
    import sysctl_pkg::*;
(
    input  logic [NPORT-1:0]  hit,
    input  logic              hit_l2,
    input  ctl_t              ctl,
    output logic [DATA_W-1:0] rval
);
    always_comb begin
        rval = K_NONE;
        if (hit[PI_SPECIAL])     rval = {{(DATA_W-2){1'b0}}, ctl.endian, 1'b0};
        else if (hit[PI_CPUCFG]) rval = K_CPUCFG;
        else if (hit[PI_FEAT])   rval = K_FEAT;
        else if (hit[PI_STAT])   rval = K_STAT;
        else if (hit[PI_EQUIP])  rval = K_EQUIP;
        else if (hit[PI_PW1])    rval = K_EXTF;
        else if (hit[PI_KEYLK])  rval = K_KEYLK;
        else if (hit[PI_SYSCTL]) rval = {{(DATA_W-SC_W){1'b0}}, ctl.sc};
        else if (hit[PI_MAP])    rval = {{(DATA_W-1){1'b0}}, ctl.cmap};
        else if (hit_l2)         rval = K_L2STAT;
    end

endmodule

// File: rtl/sysctl_regport.sv
module sysctl_regport
    import sysctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              err,
    output logic              reset_req,
    output logic              endian_le,
    output logic              disk_light,
    output logic              contig_map,
    output logic              lock_tog1,
    output logic              lock_tog2
);
    logic [NPORT-1:0]  hit;
    logic              hit_l2;
    logic              rd_ok;
    logic              wr_ok;
    ctl_t              ctl_q;
    logic [DATA_W-1:0] rval;
    bus_t              bus_d;
    bus_t              bus_q;

    sysctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (addr),
        .hit    (hit),
        .hit_l2 (hit_l2),
        .rd_ok  (rd_ok),
        .wr_ok  (wr_ok)
    );

    sysctl_ctl u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .wdata (wdata),
        .hit   (hit),
        .ctl_q (ctl_q)
    );

    sysctl_rdmux u_rdmux (
        .hit    (hit),
        .hit_l2 (hit_l2),
        .ctl    (ctl_q),
        .rval   (rval)
    );

    always_comb begin
        bus_d     = bus_q;
        bus_d.err = (rd_en && !rd_ok) || (wr_en && !wr_ok);
        if (rd_en) bus_d.rdata = rval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign rdata      = bus_q.rdata;
    assign err        = bus_q.err;
    assign reset_req  = ctl_q.rst_req;
    assign endian_le  = ctl_q.endian;
    assign disk_light = ctl_q.light;
    assign contig_map = ctl_q.cmap;
    assign lock_tog1  = ctl_q.pulse1;
    assign lock_tog2  = ctl_q.pulse2;

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    a_r9_unknown_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !rd_ok |=> rdata == 8'hFF);

    a_r4_cpucfg_id: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == ADDR_W'(16'h0800) |=> rdata == 8'hEF);

    a_r3_special_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == ADDR_W'(16'h0092) |=> rdata == {6'b0, $past(endian_le), 1'b0});

    a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(rd_en || wr_en));

    a_r11_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en && !wr_en |=> !err);

endmodule

// File: tb/sysctl_regport_tb.sv
module sysctl_regport_tb;
    localparam int S_RDATA = 0, S_ERR = 1, S_RST = 2, S_END = 3,
                   S_LIGHT = 4, S_CMAP = 5, S_P1 = 6, S_P2 = 7;

    typedef struct {
        int         sel;
        logic [7:0] val;
        int         due;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        err, reset_req, endian_le, disk_light, contig_map, lock_tog1, lock_tog2;

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    item_t sb[$];

    // model state
    logic m_rst = 0, m_end = 0, m_light = 0, m_cmap = 0;
    logic [3:0] m_sc = 0;
    logic [7:0] m_rdata = 0;

    sysctl_regport u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .err(err), .reset_req(reset_req),
        .endian_le(endian_le), .disk_light(disk_light), .contig_map(contig_map),
        .lock_tog1(lock_tog1), .lock_tog2(lock_tog2)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    function automatic logic [7:0] pick(input int sel);
        case (sel)
            S_RDATA: pick = rdata;
            S_ERR:   pick = {7'b0, err};
            S_RST:   pick = {7'b0, reset_req};
            S_END:   pick = {7'b0, endian_le};
            S_LIGHT: pick = {7'b0, disk_light};
            S_CMAP:  pick = {7'b0, contig_map};
            S_P1:    pick = {7'b0, lock_tog1};
            default: pick = {7'b0, lock_tog2};
        endcase
    endfunction

    function automatic bit wr_known(input logic [15:0] a);
        case (a)
            16'h0092, 16'h0800, 16'h0802, 16'h0803, 16'h0808,
            16'h0810, 16'h0812, 16'h081C, 16'h0850: wr_known = 1;
            default: wr_known = 0;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic [15:0] a);
        case (a)
            16'h0092: exp_rd = {6'b0, m_end, 1'b0};
            16'h0800: exp_rd = 8'hEF;
            16'h0802: exp_rd = 8'hAD;
            16'h0803: exp_rd = 8'hE0;
            16'h080C: exp_rd = 8'h3C;
            16'h0810: exp_rd = 8'h39;
            16'h0818: exp_rd = 8'h00;
            16'h081C: exp_rd = {4'b0, m_sc};
            16'h0823: exp_rd = 8'h03;
            16'h0850: exp_rd = {7'b0, m_cmap};
            default:  exp_rd = 8'hFF;
        endcase
    endfunction

    task automatic push(input int sel, input logic [7:0] v, input string tag);
        item_t it;
        it.sel = sel; it.val = v; it.due = cyc + 1; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic push_state(input bit p1, input bit p2, input string tag);
        push(S_RST,   {7'b0, m_rst},   tag);
        push(S_END,   {7'b0, m_end},   tag);
        push(S_LIGHT, {7'b0, m_light}, tag);
        push(S_CMAP,  {7'b0, m_cmap},  tag);
        push(S_P1,    {7'b0, p1},      {tag, "/R6 pulse1"});
        push(S_P2,    {7'b0, p2},      {tag, "/R6 pulse2"});
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1; rd_en = 0;
        case (a)
            16'h0092: begin m_rst = d[0]; m_end = d[1]; end
            16'h0808: m_light = d[0];
            16'h081C: m_sc = d[3:0];
            16'h0850: m_cmap = d[0];
            default: ;
        endcase
        push_state(a == 16'h0810, a == 16'h0812, tag);
        push(S_RDATA, m_rdata, {tag, "/R10 hold"});
        push(S_ERR, {7'b0, !wr_known(a)}, {tag, "/R11 err"});
    endtask

    task automatic do_read(input logic [15:0] a, input string tag);
        logic [7:0] e;
        bit known;
        @(negedge clk);
        addr = a; rd_en = 1; wr_en = 0; wdata = 8'h5A;
        e = exp_rd(a);
        known = (a == 16'h0092 || a == 16'h0800 || a == 16'h0802 || a == 16'h0803 ||
                 a == 16'h080C || a == 16'h0810 || a == 16'h0818 || a == 16'h081C ||
                 a == 16'h0823 || a == 16'h0850);
        m_rdata = e;
        push_state(0, 0, tag);
        push(S_RDATA, e, tag);
        push(S_ERR, {7'b0, !known}, {tag, "/R11 err"});
    endtask

    task automatic do_idle(input string tag);
        @(negedge clk);
        rd_en = 0; wr_en = 0;
        push_state(0, 0, tag);
        push(S_RDATA, m_rdata, {tag, "/R10 hold"});
        push(S_ERR, 8'h00, {tag, "/R11 err idle"});
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                it = sb.pop_front();
                if (it.due < cyc) check(8'hEE, it.val, {it.tag, " (missed slot)"});
                else check(pick(it.sel), it.val, it.tag);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(rdata, 8'h00, "R1 rdata");
        check({7'b0, err}, 0, "R1 err");
        check({7'b0, reset_req}, 0, "R1 reset_req");
        check({7'b0, endian_le}, 0, "R1 endian");
        check({7'b0, disk_light}, 0, "R1 light");
        check({7'b0, contig_map}, 0, "R1 cmap");
        check({6'b0, lock_tog2, lock_tog1}, 0, "R1 pulses");
        do_read(16'h081C, "R1 sc reset");

        // R4 identity constants
        do_read(16'h0800, "R4 0x800");
        do_read(16'h0802, "R4 0x802");
        do_read(16'h0803, "R4 0x803");
        do_read(16'h080C, "R4 0x80C");
        do_read(16'h0818, "R4 0x818");
        do_read(16'h0823, "R4 0x823");
        do_write(16'h0800, 8'h00, "R4 wr ignored");
        do_write(16'h0803, 8'hFF, "R4 wr ignored");
        do_read(16'h0800, "R4 0x800 after write");

        // R2 / R3 special port
        do_write(16'h0092, 8'h01, "R2 reset only");
        do_read(16'h0092, "R3 endian 0");
        do_write(16'h0092, 8'h02, "R2 endian only");
        do_read(16'h0092, "R3 endian 1");
        do_write(16'h0092, 8'hFF, "R2 both");
        do_read(16'h0092, "R3 all ones write");
        do_write(16'h0092, 8'h00, "R2 clear");

        // R5 light
        do_write(16'h0808, 8'h01, "R5 set");
        do_write(16'h0808, 8'hFE, "R5 clear");
        do_write(16'h0808, 8'h81, "R5 set again");

        // R6 lock pulses
        do_write(16'h0810, 8'hAA, "R6 ch1");
        do_idle("R6 ch1 end");
        do_write(16'h0812, 8'h00, "R6 ch2");
        do_write(16'h0812, 8'hFF, "R6 ch2 back-to-back");
        do_idle("R6 ch2 end");
        do_read(16'h0810, "R9 0x810 ext feature");

        // R7 system control
        do_write(16'h081C, 8'hA5, "R7 write");
        do_read(16'h081C, "R7 read");
        do_write(16'h081C, 8'hFF, "R7 write ff");
        do_read(16'h081C, "R7 read ff");

        // R8 map mode
        do_write(16'h0850, 8'h03, "R8 set");
        do_read(16'h0850, "R8 read 1");
        do_write(16'h0850, 8'h02, "R8 clear");
        do_read(16'h0850, "R8 read 0");
        do_write(16'h0850, 8'h01, "R8 set again");

        // R9 / R11 undecoded
        do_read(16'h0814, "R9 0x814");
        do_read(16'h0808, "R9 0x808");
        do_read(16'h0812, "R9 0x812");
        do_read(16'h0000, "R9 0x000");
        do_read(16'h0851, "R9 0x851");
        do_write(16'h0814, 8'hFF, "R9 wr 0x814");
        do_write(16'h0823, 8'h00, "R9 wr 0x823");
        do_write(16'h080C, 8'h00, "R9 wr 0x80C");
        do_write(16'h0818, 8'h00, "R9 wr 0x818");
        do_read(16'h0850, "R9 map untouched");
        do_read(16'h081C, "R9 sc untouched");

        // R10 hold over idles
        do_read(16'h0803, "R10 read");
        do_idle("R10 idle1");
        do_idle("R10 idle2");

        repeat (3) @(negedge clk);
        check(8'(sb.size()), 8'd0, "scoreboard drained");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule